// File: doc/BRIEF.md
# Quadrature Position Decoder

The block turns the two phase signals of an incremental encoder and its once-per-turn index mark into a 16-bit position count. Each of the three raw inputs is synchronized and then cleaned by a digital filter that samples at a rate divided down from the system clock. The filter accepts a new level only after it has been seen on three sample ticks in a row. One divide setting covers all three filters.

Two counting resolutions are offered. In the fine mode every edge of either phase moves the count. In the coarse mode only phase A edges move it. When both phases flip on the same sample, the transition is illegal. The count is then held and an error pulse is raised unless it is masked. A rising index mark clears the count, but only while the filtered phases match a programmed two-bit pattern. How that pattern is read depends on the counting mode. The filtered signals can be brought out for observation.

Top module: `quad_decoder`

## Requirements
- R1: While rst_ni is low, pos_o, err_irq_o, pha_filt_o, phb_filt_o and idx_filt_o are all 0.
- R2: A filtered input takes a new level only after the synchronized raw input has held that level on 3 consecutive sample ticks. A raw pulse lasting 2 clocks at divide-by-1 never reaches the filtered signal. At divide-by-1, a single phase change driven before a clock edge shows on pos_o after the 6th rising edge and not after the 5th.
- R3: div_sel_i selects the sample tick rate as 0:/1, 1:/2, 2:/4, 3:/16, 4:/32, 5:/64, 6:/128, 7:/256. With divisor N, a filtered output follows a raw change after between 2N+3 and 3N+2 rising edges.
- R4: With mode_2x_i=0, every filtered edge of A or B moves pos_o by one. The {A,B} sequence 00,10,11,01 counts up and the reverse order counts down.
- R5: With mode_2x_i=1, only filtered edges of A move pos_o, using the same direction rule. Edges of B alone leave pos_o unchanged.
- R6: If both filtered phases change on the same sample, pos_o is unchanged. With err_irq_dis_i=0, err_irq_o pulses high for exactly one clock.
- R7: With err_irq_dis_i=1, a count error produces no err_irq_o pulse.
- R8: With mode_2x_i=0, a rising filtered index clears pos_o to 0 only when A equals idx_match_i[0] and B equals idx_match_i[1]. Otherwise the count is unaffected.
- R9: With mode_2x_i=1, idx_match_i[1] selects the compared phase (0 = A, 1 = B). A rising filtered index clears pos_o only when that phase equals idx_match_i[0].
- R10: An index clear that coincides with a count step wins, and pos_o becomes 0.
- R11: With filt_out_en_i=1, pha_filt_o, phb_filt_o and idx_filt_o show the filtered A, B and index. With filt_out_en_i=0 they are held at 0.
- R12: pos_o wraps modulo 2^16, so one down step from 0 gives 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pha_i | input | 1 | Raw phase A |
| phb_i | input | 1 | Raw phase B |
| idx_i | input | 1 | Raw index mark |
| mode_2x_i | input | 1 | 0 = count edges of both phases, 1 = count edges of A only |
| div_sel_i | input | 3 | Filter sample clock divide select |
| idx_match_i | input | 2 | Phase pattern required for an index clear |
| err_irq_dis_i | input | 1 | 1 masks the count-error pulse |
| filt_out_en_i | input | 1 | 1 drives the filtered signals out |
| pos_o | output | 16 | Position count |
| err_irq_o | output | 1 | Count-error pulse |
| pha_filt_o | output | 1 | Filtered phase A when enabled |
| phb_filt_o | output | 1 | Filtered phase B when enabled |
| idx_filt_o | output | 1 | Filtered index when enabled |

## Verification
A raw change passes two synchronizer stages and then waits for three sample ticks. With divisor N, the filtered outputs therefore move between 2N+3 and 3N+2 edges after the stimulus. pos_o and err_irq_o follow one edge later. At divide-by-1 the bench samples pos_o exactly after edges 5 and 6 to pin the latency down. For each divide select it counts the edges up to the filtered change and checks them against the bound. Every other check waits 3N+8 cycles after the stimulus and samples on the falling edge, so a result is only read once it is due. Error pulses are tallied on every falling edge, so a missing pulse or a second one is caught.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic {
    MODE_4X = 1'b0,
    MODE_2X = 1'b1
  } cnt_mode_e;

  // Select 3 jumps from /4 to /16; no /8 setting exists.
  function automatic int unsigned div_ratio(input logic [2:0] sel);
    int unsigned s;
    s = {29'b0, sel};
    if (s == 0) return 1;
    if (s == 1) return 2;
    if (s == 2) return 4;
    return 32'd1 << (s + 1);
  endfunction
endpackage

// File: rtl/qdec_clkdiv.sv
module qdec_clkdiv #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PAD_W = 32 - CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      last_w;

  always_comb begin
    last_w = qdec_pkg::div_ratio(sel_i) - 32'd1;
    // >= keeps the divider sane when the select shrinks mid-count
    tick_o = ({{PAD_W{1'b0}}, cnt_q} >= last_w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o
);
  localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [RUN_W-1:0]       run_q;
  logic                   smp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      filt_o <= 1'b0;
    end else if (tick_i) begin
      if (smp == filt_o) begin
        run_q <= '0;
      end else if (run_q == RUN_W'(FILT_LEN - 1)) begin
        filt_o <= smp;
        run_q  <= '0;
      end else begin
        run_q <= run_q + RUN_W'(1);
      end
    end
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int POS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_2x_i,
  input  logic [1:0]       match_i,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             idx_i,
  output logic [POS_W-1:0] pos_o,
  output logic             err_o
);
  import qdec_pkg::*;

  cnt_mode_e  mode;
  logic       a_q, b_q, i_q;
  logic       a_ch, b_ch, step_en, step_up;
  logic       pat_hit, idx_rise;

  assign mode = cnt_mode_e'(mode_2x_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      i_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
      i_q <= idx_i;
    end
  end

  always_comb begin
    a_ch  = a_i ^ a_q;
    b_ch  = b_i ^ b_q;
    err_o = a_ch & b_ch;
    if (mode == MODE_2X) step_en = a_ch & ~b_ch;
    else                 step_en = a_ch ^ b_ch;
    // A leading B counts up
    step_up = a_ch ? (a_i ^ b_i) : ~(a_i ^ b_i);
    if (mode == MODE_2X)
      pat_hit = ((match_i[1] ? b_i : a_i) == match_i[0]);
    else
      pat_hit = (a_i == match_i[0]) && (b_i == match_i[1]);
    idx_rise = idx_i & ~i_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pos_o <= '0;
    else if (idx_rise && pat_hit) pos_o <= '0;
    else if (step_en) begin
      if (step_up) pos_o <= pos_o + POS_W'(1);
      else         pos_o <= pos_o - POS_W'(1);
    end
  end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int POS_W       = 16,
  parameter int DIV_SEL_W   = 3,
  parameter int DIV_CNT_W   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pha_i,
  input  logic                 phb_i,
  input  logic                 idx_i,
  input  logic                 mode_2x_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [1:0]           idx_match_i,
  input  logic                 err_irq_dis_i,
  input  logic                 filt_out_en_i,
  output logic [POS_W-1:0]     pos_o,
  output logic                 err_irq_o,
  output logic                 pha_filt_o,
  output logic                 phb_filt_o,
  output logic                 idx_filt_o
);
  localparam int N_IN = 3;

  logic            smp_tick;
  logic [N_IN-1:0] raw_vec, flt_vec;
  logic            a_flt, b_flt, i_flt;
  logic            err_evt;

  qdec_clkdiv #(
    .SEL_W (DIV_SEL_W),
    .CNT_W (DIV_CNT_W)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (div_sel_i),
    .tick_o (smp_tick)
  );

  assign raw_vec = {idx_i, phb_i, pha_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_flt
    qdec_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (smp_tick),
      .raw_i  (raw_vec[g]),
      .filt_o (flt_vec[g])
    );
  end

  assign a_flt = flt_vec[0];
  assign b_flt = flt_vec[1];
  assign i_flt = flt_vec[2];

  qdec_counter #(
    .POS_W (POS_W)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_2x_i (mode_2x_i),
    .match_i   (idx_match_i),
    .a_i       (a_flt),
    .b_i       (b_flt),
    .idx_i     (i_flt),
    .pos_o     (pos_o),
    .err_o     (err_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_irq_o <= 1'b0;
    else         err_irq_o <= err_evt & ~err_irq_dis_i;
  end

  assign pha_filt_o = filt_out_en_i & a_flt;
  assign phb_filt_o = filt_out_en_i & b_flt;
  assign idx_filt_o = filt_out_en_i & i_flt;
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int POS_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_2x_i,
  input logic             err_irq_dis_i,
  input logic             err_irq_o,
  input logic [POS_W-1:0] pos_o,
  input logic             smp_tick,
  input logic             a_flt,
  input logic             b_flt,
  input logic             i_flt
);
  // R2
  filt_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(a_flt) || !$stable(b_flt) || !$stable(i_flt)) |-> $past(smp_tick));

  // R4
  quiet_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(a_flt) && $stable(b_flt) && $stable(i_flt)) |=> $stable(pos_o));

  // R12
  unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pos_o) |-> (pos_o == $past(pos_o) + POS_W'(1) ||
                         pos_o == $past(pos_o) - POS_W'(1) || pos_o == '0));

  // R5
  b_only_2x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_2x_i && $stable(a_flt) && $stable(i_flt)) |=> $stable(pos_o));

  // R6
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(a_flt) && !$stable(b_flt) && $stable(i_flt)) |=> $stable(pos_o));

  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(a_flt) && !$stable(b_flt) && !err_irq_dis_i) |=> err_irq_o);

  // R7
  err_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> !$past(err_irq_dis_i));
endmodule

bind quad_decoder qdec_checker #(.POS_W(POS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_2x_i     (mode_2x_i),
  .err_irq_dis_i (err_irq_dis_i),
  .err_irq_o     (err_irq_o),
  .pos_o         (pos_o),
  .smp_tick      (smp_tick),
  .a_flt         (a_flt),
  .b_flt         (b_flt),
  .i_flt         (i_flt)
);

// File: tb/quad_decoder_tb.sv
`timescale 1ns/1ps
module quad_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pha = 1'b0, phb = 1'b0, idx = 1'b0;
  logic        mode2x = 1'b0, irq_dis = 1'b0, fo_en = 1'b0;
  logic [2:0]  div_sel = 3'd0;
  logic [1:0]  imatch = 2'd0;
  logic [15:0] pos;
  logic        irq, fa, fb, fi;

  int n_chk = 0, n_bad = 0, irq_cnt = 0;
  int ph = 0, exp_pos = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pha_i(pha), .phb_i(phb), .idx_i(idx),
    .mode_2x_i(mode2x), .div_sel_i(div_sel), .idx_match_i(imatch),
    .err_irq_dis_i(irq_dis), .filt_out_en_i(fo_en), .pos_o(pos),
    .err_irq_o(irq), .pha_filt_o(fa), .phb_filt_o(fb), .idx_filt_o(fi)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  function automatic int ratio(input int sel);
    case (sel)
      0: return 1;   1: return 2;   2: return 4;   3: return 16;
      4: return 32;  5: return 64;  6: return 128; default: return 256;
    endcase
  endfunction
  function automatic bit st_a(input int p); return (p == 1 || p == 2); endfunction
  function automatic bit st_b(input int p); return (p == 2 || p == 3); endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3 * ratio(div_sel) + 8) @(negedge clk);
  endtask

  task automatic drive_ph();
    pha = st_a(ph);
    phb = st_b(ph);
  endtask

  task automatic step(input bit up);
    int np;
    np = up ? (ph + 1) % 4 : (ph + 3) % 4;
    if (!mode2x || st_a(np) != st_a(ph)) exp_pos = (exp_pos + (up ? 1 : -1)) & 16'hFFFF;
    ph = np;
    drive_ph();
    settle();
  endtask

  task automatic idx_pulse();
    idx = 1'b1; settle();
    idx = 1'b0; settle();
  endtask

  task automatic idx_sweep(input string req);
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 4; t++) begin
        bit hit;
        imatch = 2'(m);
        while (ph != t) step(1);
        repeat (4) step(1);
        if (mode2x) hit = ((m[1] ? st_b(ph) : st_a(ph)) == m[0]);
        else        hit = (st_a(ph) == m[0]) && (st_b(ph) == m[1]);
        idx_pulse();
        if (hit) exp_pos = 0;
        check(req, int'(pos), exp_pos);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base, irq0, seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pos", int'(pos), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 filt", int'({fa, fb, fi}), 0);
    fo_en = 1'b1;
    @(negedge clk);
    check("R1 filt en", int'({fa, fb, fi}), 0);
    fo_en = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R12 wrap below zero and back
    step(0);
    check("R12 wrap", int'(pos), 65535);
    step(1);
    check("R12 unwrap", int'(pos), 0);

    // R4 fine mode, both directions
    for (int k = 0; k < 10; k++) begin step(1); check("R4 up", int'(pos), exp_pos); end
    for (int k = 0; k < 6; k++)  begin step(0); check("R4 down", int'(pos), exp_pos); end

    // R2 exact latency at /1
    base = exp_pos;
    ph = (ph + 1) % 4;
    drive_ph();
    repeat (5) @(negedge clk);
    check("R2 edge5", int'(pos), base);
    @(negedge clk);
    exp_pos = (exp_pos + 1) & 16'hFFFF;
    check("R2 edge6", int'(pos), exp_pos);
    settle();

    // R2 glitch rejection and acceptance on the filtered output
    fo_en = 1'b1;
    repeat (2) step(1);            // ph now has A = st_a(ph)
    begin
      bit a0;
      a0 = st_a(ph);
      seen = 0;
      pha = ~a0; repeat (2) @(negedge clk); pha = a0;
      repeat (12) begin @(negedge clk); if (fa != a0) seen = 1; end
      check("R2 short pulse", seen, 0);
      seen = 0;
      pha = ~a0; repeat (3) @(negedge clk); pha = a0;
      repeat (12) begin @(negedge clk); if (fa != a0) seen = 1; end
      check("R2 long pulse", seen, 1);
      settle();
      check("R2 net pos", int'(pos), exp_pos);
    end

    // R11 filtered outputs gated by enable
    imatch = 2'b00;
    while (ph != 2) step(1);
    idx = 1'b1; settle();
    fo_en = 1'b0; @(negedge clk);
    check("R11 off", int'({fa, fb, fi}), 0);
    fo_en = 1'b1; @(negedge clk);
    check("R11 on", int'({fa, fb, fi}), 7);
    idx = 1'b0; settle();
    check("R11 pos kept", int'(pos), exp_pos);

    // R6 error with pulse
    irq_dis = 1'b0;
    irq0 = irq_cnt;
    ph = (ph + 2) % 4; drive_ph(); settle();
    check("R6 pos held", int'(pos), exp_pos);
    check("R6 one pulse", irq_cnt - irq0, 1);
    // R7 masked error
    irq_dis = 1'b1;
    irq0 = irq_cnt;
    ph = (ph + 2) % 4; drive_ph(); settle();
    check("R7 pos held", int'(pos), exp_pos);
    check("R7 no pulse", irq_cnt - irq0, 0);
    irq_dis = 1'b0;

    // R5 coarse mode
    mode2x = 1'b1;
    for (int k = 0; k < 8; k++) begin step(1); check("R5 up", int'(pos), exp_pos); end
    for (int k = 0; k < 4; k++) begin step(0); check("R5 down", int'(pos), exp_pos); end

    // R9 coarse mode index pattern sweep
    idx_sweep("R9");
    // R8 fine mode index pattern sweep
    mode2x = 1'b0;
    idx_sweep("R8");

    // R10 index clear beats a simultaneous step
    repeat (4) step(1);
    begin
      int np;
      np = (ph + 1) % 4;
      imatch = {st_b(np), st_a(np)};
      ph = np;
      drive_ph();
      idx = 1'b1;
      settle();
      exp_pos = 0;
      check("R10 priority", int'(pos), 0);
      idx = 1'b0; settle();
    end

    // R3 divide sweep via latency of the filtered A output
    fo_en = 1'b1;
    for (int s = 0; s < 8; s++) begin
      int n, lat;
      bit a0;
      div_sel = 3'(s);
      n = ratio(s);
      settle();
      a0 = fa;
      lat = 0;
      pha = ~pha;
      while (fa == a0 && lat < 2000) begin
        @(posedge clk); lat++;
        @(negedge clk);
      end
      n_chk++;
      if (lat < 2 * n + 3 || lat > 3 * n + 2) begin
        n_bad++;
        $display("FAIL R3 sel=%0d act=%0d exp=%0d..%0d", s, lat, 2 * n + 3, 3 * n + 2);
      end
      settle();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule